// File: doc/BRIEF.md
# Watchdog Timer with Shared Scaler

This block is the watchdog of a small microcontroller. A base counter advances on every cycle of a dedicated low-frequency oscillator, seen here as a single-cycle enable `osc_tick` in the block's clock domain. An 8-bit binary scaler is shared with the general-purpose timer. When `scaler_owner` is 1 the scaler extends the watchdog period as a postscaler. When it is 0 the scaler divides the timer's clock source as a prescaler, and the watchdog then expires directly at the base period. A 3-bit ratio code picks one of eight taps of the scaler.

Software restarts the count with a clear strobe. Entering sleep gives the same restart through a sleep strobe. When the count expires, the block raises a one-cycle device-reset pulse if the core is awake. If the core is asleep, it raises a one-cycle wake pulse instead. An active-low status flag records that an expiry happened. A configuration enable turns the whole watchdog off, and the oscillator request output follows that enable. All pins are plain control and status signals: the block carries no data stream, so there is no valid/ready handshake.

Top module: `wdt_shared_scaler`

## Requirements
- R1: After `rst_n` is released with no further stimulus, `wdt_reset` and `wdt_wake` are 0 and `to_n` is 1.
- R2: `osc_en` equals `cfg_en`. While `cfg_en` is 0 the counters hold their values and no `wdt_reset` or `wdt_wake` pulse ever appears, whatever `osc_tick` does.
- R3: With `scaler_owner`=1 and ratio code `ratio`=k (0..7), expiry happens on the (2^BASE_W · 2^k)-th `osc_tick` after a restart.
- R4: With `scaler_owner`=0, expiry happens on every 2^BASE_W-th `osc_tick` after a restart, for any ratio code.
- R5: With `scaler_owner`=0 and ratio code k, `tmr_tick` is high together with one `tmr_src` pulse in every 2^(k+1). It is combinational with `tmr_src`, so 512 source pulses give exactly 256/2^k output ticks.
- R6: With `scaler_owner`=1, `tmr_tick` equals `tmr_src` on every cycle.
- R7: A `clr_strobe` restarts the base count, and also restarts the scaler count when `scaler_owner`=1. A full period is then needed again before expiry.
- R8: A `sleep_strobe` restarts the counts exactly as `clr_strobe` does.
- R9: An expiry gives a pulse one cycle wide in the cycle after the edge that took the final `osc_tick`. The pulse is on `wdt_reset` when `asleep` was 0 at that edge, and on `wdt_wake` when `asleep` was 1. The two pulses never appear together.
- R10: `to_n` goes to 0 with every expiry pulse. A `clr_strobe` or `sleep_strobe` sets it back to 1 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset |
| cfg_en | input | 1 | Configuration enable of the watchdog |
| osc_tick | input | 1 | One pulse per watchdog oscillator cycle |
| tmr_src | input | 1 | One pulse per timer clock-source edge |
| scaler_owner | input | 1 | 1: scaler is the watchdog postscaler; 0: scaler is the timer prescaler |
| ratio | input | 3 | Scaler tap select |
| clr_strobe | input | 1 | Watchdog clear strobe |
| sleep_strobe | input | 1 | Sleep-entry strobe |
| asleep | input | 1 | Core is in sleep |
| osc_en | output | 1 | Request to run the watchdog oscillator |
| tmr_tick | output | 1 | Clock enable toward the timer counter |
| wdt_reset | output | 1 | Device-reset pulse on expiry while awake |
| wdt_wake | output | 1 | Wake-up pulse on expiry while asleep |
| to_n | output | 1 | Active-low expiry status flag |

## Verification
The bench uses a 3-bit base counter so that full periods stay short. It measures the number of oscillator ticks to expiry for all eight ratio codes with the scaler on the watchdog. Each code has its own count, so a wrong tap or a misplaced shift shows as a distinct number. With the scaler on the timer, it checks that the period ignores the ratio code. It also counts timer ticks over 512 source pulses for each code, which separates the prescaler's divide-by-2^(k+1) from the postscaler's divide-by-2^k. Restarts issued part-way through a period must bring back a full period, which exposes a scaler that is not cleared. An expiry in sleep must give a wake pulse and no reset pulse, and a disabled watchdog must stay silent.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    OWNER_TIMER = 1'b0,
    OWNER_WDT   = 1'b1
  } scaler_owner_e;
endpackage

// File: rtl/wdt_base_counter.sv
module wdt_base_counter #(
  parameter int BASE_W = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic osc_tick,
  input  logic restart,
  output logic ovf
);
  logic [BASE_W-1:0] cnt_q;
  logic              step;

  assign step = en && osc_tick && !restart;
  assign ovf  = step && (cnt_q == {BASE_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_scaler.sv
module wdt_scaler
  import wdt_pkg::*;
#(
  parameter int SCALE_W = 8,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  scaler_owner_e    owner,
  input  logic [SEL_W-1:0] sel,
  input  logic             tmr_src,
  input  logic             wdt_evt,
  input  logic             restart,
  output logic             tmr_tick,
  output logic             wdt_hit
);
  localparam int TAPS = 1 << SEL_W;

  logic [SCALE_W-1:0] cnt_q;
  logic [TAPS-1:0]    wdt_full;
  logic [TAPS-1:0]    tmr_full;
  logic               evt;
  logic               clear;

  // Tap i for the watchdog is reached when the low i bits are all ones;
  // for the timer the low i+1 bits must be all ones.
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    localparam logic [SCALE_W-1:0] WMASK = SCALE_W'((1 << i) - 1);
    localparam logic [SCALE_W-1:0] TMASK = SCALE_W'((2 << i) - 1);
    assign wdt_full[i] = (cnt_q & WMASK) == WMASK;
    assign tmr_full[i] = (cnt_q & TMASK) == TMASK;
  end

  assign clear = restart && (owner == OWNER_WDT);
  assign evt   = (owner == OWNER_WDT) ? wdt_evt : tmr_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (evt)   cnt_q <= cnt_q + 1'b1;
  end

  assign wdt_hit  = (owner == OWNER_WDT) && wdt_evt && wdt_full[sel];
  assign tmr_tick = (owner == OWNER_WDT) ? tmr_src : (tmr_src && tmr_full[sel]);
endmodule

// File: rtl/wdt_timeout_ctrl.sv
module wdt_timeout_ctrl
  import wdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  scaler_owner_e owner,
  input  logic          base_ovf,
  input  logic          scaler_hit,
  input  logic          asleep,
  input  logic          restart,
  output logic          rst_pulse,
  output logic          wake_pulse,
  output logic          to_n
);
  logic expire;

  assign expire = (owner == OWNER_WDT) ? scaler_hit : base_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pulse  <= 1'b0;
      wake_pulse <= 1'b0;
      to_n       <= 1'b1;
    end else begin
      rst_pulse  <= expire && !asleep;
      wake_pulse <= expire && asleep;
      if (restart)     to_n <= 1'b1;
      else if (expire) to_n <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_shared_scaler.sv
module wdt_shared_scaler
  import wdt_pkg::*;
#(
  parameter int BASE_W  = 9,
  parameter int SCALE_W = 8,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             osc_tick,
  input  logic             tmr_src,
  input  logic             scaler_owner,
  input  logic [SEL_W-1:0] ratio,
  input  logic             clr_strobe,
  input  logic             sleep_strobe,
  input  logic             asleep,
  output logic             osc_en,
  output logic             tmr_tick,
  output logic             wdt_reset,
  output logic             wdt_wake,
  output logic             to_n
);
  scaler_owner_e owner;
  logic          restart;
  logic          base_ovf;
  logic          scaler_hit;

  assign owner   = scaler_owner_e'(scaler_owner);
  assign restart = clr_strobe || sleep_strobe;
  assign osc_en  = cfg_en;

  wdt_base_counter #(.BASE_W(BASE_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg_en),
    .osc_tick (osc_tick),
    .restart  (restart),
    .ovf      (base_ovf)
  );

  wdt_scaler #(.SCALE_W(SCALE_W), .SEL_W(SEL_W)) u_scaler (
    .clk      (clk),
    .rst_n    (rst_n),
    .owner    (owner),
    .sel      (ratio),
    .tmr_src  (tmr_src),
    .wdt_evt  (base_ovf),
    .restart  (restart),
    .tmr_tick (tmr_tick),
    .wdt_hit  (scaler_hit)
  );

  wdt_timeout_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .owner      (owner),
    .base_ovf   (base_ovf),
    .scaler_hit (scaler_hit),
    .asleep     (asleep),
    .restart    (restart),
    .rst_pulse  (wdt_reset),
    .wake_pulse (wdt_wake),
    .to_n       (to_n)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic asleep,
  input logic clr_strobe,
  input logic sleep_strobe,
  input logic wdt_reset,
  input logic wdt_wake,
  input logic to_n
);
  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wdt_reset && wdt_wake));

  p_wake_in_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_wake) |-> $past(asleep));

  p_reset_when_awake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_reset) |-> !$past(asleep));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);

  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (!wdt_reset && !wdt_wake));

  p_flag_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_reset || wdt_wake) |-> !to_n);

  p_flag_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_strobe || sleep_strobe) |=> to_n);
endmodule

bind wdt_shared_scaler wdt_checker u_wdt_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_en       (cfg_en),
  .asleep       (asleep),
  .clr_strobe   (clr_strobe),
  .sleep_strobe (sleep_strobe),
  .wdt_reset    (wdt_reset),
  .wdt_wake     (wdt_wake),
  .to_n         (to_n)
);

// File: tb/wdt_shared_scaler_bench.sv
`timescale 1ns/1ps
module wdt_shared_scaler_bench;
  localparam int BW   = 3;
  localparam int BASE = 1 << BW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b1;
  logic       osc_tick = 1'b0;
  logic       tmr_src = 1'b0;
  logic       scaler_owner = 1'b1;
  logic [2:0] ratio = 3'd0;
  logic       clr_strobe = 1'b0;
  logic       sleep_strobe = 1'b0;
  logic       asleep = 1'b0;
  logic       osc_en, tmr_tick, wdt_reset, wdt_wake, to_n;

  int errors = 0;
  int checks = 0;
  int n;
  bit woke;
  bit seen;

  always #2 clk = ~clk;

  wdt_shared_scaler #(.BASE_W(BW)) u_wdt_shared_scaler (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .osc_tick(osc_tick),
    .tmr_src(tmr_src), .scaler_owner(scaler_owner), .ratio(ratio),
    .clr_strobe(clr_strobe), .sleep_strobe(sleep_strobe), .asleep(asleep),
    .osc_en(osc_en), .tmr_tick(tmr_tick), .wdt_reset(wdt_reset),
    .wdt_wake(wdt_wake), .to_n(to_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // One oscillator tick; samples the outputs in the cycle after the edge.
  task automatic osc_pulse(output bit r, output bit w);
    @(negedge clk) osc_tick = 1'b1;
    @(negedge clk) osc_tick = 1'b0;
    r = wdt_reset;
    w = wdt_wake;
  endtask

  task automatic do_clear();
    @(negedge clk) clr_strobe = 1'b1;
    @(negedge clk) clr_strobe = 1'b0;
  endtask

  task automatic do_sleep();
    @(negedge clk) sleep_strobe = 1'b1;
    @(negedge clk) sleep_strobe = 1'b0;
  endtask

  task automatic ticks(input int count);
    bit r, w;
    for (int i = 0; i < count; i++) osc_pulse(r, w);
  endtask

  // Number of ticks up to the first expiry pulse; 0 if none within limit.
  task automatic ticks_to_expiry(input int limit, output int cnt, output bit wk);
    bit r, w;
    cnt = 0;
    wk = 1'b0;
    for (int i = 1; i <= limit; i++) begin
      osc_pulse(r, w);
      if (r || w) begin
        cnt = i;
        wk = w;
        break;
      end
    end
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(wdt_reset == 1'b0, "R1 wdt_reset", wdt_reset, 0);
    check(wdt_wake == 1'b0, "R1 wdt_wake", wdt_wake, 0);
    check(to_n == 1'b1, "R1 to_n", to_n, 1);
    check(osc_en == 1'b1, "R2 osc_en", osc_en, 1);

    // R3 postscaler period sweep, R9 awake expiry, R10 flag
    scaler_owner = 1'b1;
    for (int k = 0; k < 8; k++) begin
      ratio = 3'(k);
      do_clear();
      ticks_to_expiry(4000, n, woke);
      check(n == (BASE << k), "R3 period", n, BASE << k);
      check(woke == 1'b0, "R9 reset not wake", woke, 0);
      check(to_n == 1'b0, "R10 flag low", to_n, 0);
      do_clear();
      check(to_n == 1'b1, "R10 flag restored", to_n, 1);
    end

    // R4 watchdog period without postscaler ignores ratio
    scaler_owner = 1'b0;
    for (int k = 0; k < 8; k += 7) begin
      ratio = 3'(k);
      do_clear();
      ticks_to_expiry(4000, n, woke);
      check(n == BASE, "R4 base period", n, BASE);
    end

    // R5 prescaler ratios over 512 source pulses
    for (int k = 0; k < 8; k++) begin
      int got;
      ratio = 3'(k);
      got = 0;
      for (int i = 0; i < 512; i++) begin
        @(negedge clk) tmr_src = 1'b1;
        #1;
        if (tmr_tick) got++;
        @(negedge clk) tmr_src = 1'b0;
      end
      check(got == (256 >> k), "R5 prescale count", got, 256 >> k);
    end

    // R6 passthrough with scaler on the watchdog
    scaler_owner = 1'b1;
    ratio = 3'd5;
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) tmr_src = 1'b1;
      #1;
      if (!tmr_tick) seen = 1'b1;
      @(negedge clk) tmr_src = 1'b0;
      #1;
      if (tmr_tick) seen = 1'b1;
    end
    check(seen == 1'b0, "R6 passthrough", seen, 0);

    // R7 clear mid-period restarts base and scaler
    ratio = 3'd2;
    do_clear();
    ticks(20);
    do_clear();
    ticks_to_expiry(4000, n, woke);
    check(n == 4 * BASE, "R7 clear restart (scaler)", n, 4 * BASE);

    scaler_owner = 1'b0;
    do_clear();
    ticks(5);
    do_clear();
    ticks_to_expiry(4000, n, woke);
    check(n == BASE, "R7 clear restart (base)", n, BASE);

    // R8 sleep strobe restarts; R9 expiry in sleep wakes
    scaler_owner = 1'b1;
    ratio = 3'd1;
    do_clear();
    ticks(10);
    do_sleep();
    asleep = 1'b1;
    ticks_to_expiry(4000, n, woke);
    check(n == 2 * BASE, "R8 sleep restart", n, 2 * BASE);
    check(woke == 1'b1, "R9 wake in sleep", woke, 1);
    check(wdt_reset == 1'b0, "R9 no reset in sleep", wdt_reset, 0);
    check(to_n == 1'b0, "R10 flag low on wake", to_n, 0);
    do_sleep();
    check(to_n == 1'b1, "R10 flag restored by sleep", to_n, 1);
    asleep = 1'b0;

    // R2 disabled watchdog never expires
    ratio = 3'd0;
    cfg_en = 1'b0;
    @(negedge clk);
    check(osc_en == 1'b0, "R2 osc_en off", osc_en, 0);
    ticks_to_expiry(300, n, woke);
    check(n == 0, "R2 disabled no expiry", n, 0);
    cfg_en = 1'b1;
    @(negedge clk);
    check(osc_en == 1'b1, "R2 osc_en on", osc_en, 1);

    finish_run();
  end
endmodule